// File: doc/BRIEF.md
# Next Program-Counter Selector

This combinational unit works out the program counter of the instruction that follows the one now being executed on an 8-bit accumulator machine with a 16-bit address space. The processor gives it the address of the opcode, the opcode, up to two operand bytes, the accumulator, the data pointer, four status flags, a return address already popped from the stack, and one register-derived byte for the loop and compare branches. From these it returns the next PC and a flag that says whether control left the straight-line path.

The unit also decodes the byte length of every opcode. This lets it form the sequential address (opcode address plus length) without help from fetch. That sequential address is also given out as the value a call must push. The unit does not touch stack memory and does not take part in fetch timing.

All address arithmetic wraps modulo 2^16. Operand byte 1 (`opnd1`) is the byte right after the opcode. Operand byte 2 (`opnd2`) is the byte after that.

Top module: `npc_unit`

## Requirements
- R1: Opcode length is 3 bytes for 0x16, 0x17, 0x18, 0x19, 0x1C, 0x1D, 0xD4–0xD9 and 0xDF. It is 2 bytes for 0x15, 0x28–0x2F, 0x86, 0x8E, 0x96, 0xA6, 0xAE, 0xB6, 0xBE, 0xC0–0xD3, 0xDC, 0xE0–0xE7 and 0xFC–0xFE. It is 1 byte for all others. A non-branching opcode gives `taken`=0 and `next_pc` = `pc` + length.
- R2: Unallocated codes (0x01–0x07, 0xFB) and every opcode outside 0xC0–0xE7 behave as non-branching: `taken`=0 and `next_pc` is the sequential address.
- R3: Codes 0xC0–0xCF (page jump and page call) give `taken`=1 and a target built as `pc`[15:11], then opcode[2:0] in bits 10:8, then `opnd1` in bits 7:0.
- R4: Codes 0xD8 and 0xD9 (long jump and long call) give `taken`=1 and target {`opnd1`,`opnd2`}, with `opnd1` as the high byte.
- R5: Code 0xDC gives `taken`=1 and target (`pc`+2) plus `opnd1` read as a signed two's-complement byte.
- R6: Code 0xDD gives `taken`=1 and target `dptr` + zero-extended `acc`. Code 0xDE gives `taken`=1 and target `dptr`.
- R7: Codes 0xE0 to 0xE7 branch, in that order, when: zero set, zero clear, carry set, carry clear, odd parity set, odd parity clear, sign set, sign clear. When taken, the target is (`pc`+2)+signed `opnd1`. Otherwise `next_pc` is `pc`+2.
- R8: Codes 0xD0–0xD3 branch when `loop_val` (the already decremented register) is non-zero. The target is (`pc`+2)+signed `opnd1`.
- R9: Codes 0xD4–0xD7 and 0xDF branch when `loop_val` (the register or accumulator being compared) differs from `opnd1`. The target is (`pc`+3)+signed `opnd2`.
- R10: Codes 0xDA and 0xDB (returns) give `taken`=1 and `next_pc` = `ret_addr`.
- R11: `push_addr` equals `pc` + opcode length for every opcode. This is the return address a call pushes.
- R12: Every sum (sequential, relative, indexed) wraps modulo 2^16. For example, `pc`=0xFFFE with a 3-byte opcode gives a sequential address of 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 16 | Address of the current opcode |
| opcode | input | 8 | Current opcode |
| opnd1 | input | 8 | First byte after the opcode |
| opnd2 | input | 8 | Second byte after the opcode |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| flag_zero | input | 1 | Zero flag |
| flag_carry | input | 1 | Carry flag |
| flag_par_odd | input | 1 | Parity flag, 1 when parity is odd |
| flag_sign | input | 1 | Sign flag |
| loop_val | input | 8 | Decremented register for the loop branch, or the compared value for the compare branch |
| ret_addr | input | 16 | Return address popped from the stack |
| next_pc | output | 16 | Address of the next instruction |
| taken | output | 1 | Control left the sequential path |
| push_addr | output | 16 | Sequential address, pushed by calls |

## Verification
The hard cases sit where an operand sum crosses the 16-bit boundary in either direction: a backward offset from a low address, a forward offset or a long opcode from near 0xFFFF, and an indexed jump with `dptr` near the top of memory. Each also needs its branch condition to agree. The bench sweeps all 256 opcodes against all sixteen flag combinations at several PC values, including 0xFFFF and a page edge. It derives the offset sign, `loop_val` and the operand bytes from the flag index, so every conditional opcode is seen both taken and not taken, with positive and negative offsets, on both sides of the wrap.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    TGT_SEQ,
    TGT_PAGE,
    TGT_LONG,
    TGT_REL_B1,
    TGT_REL_B2,
    TGT_IDX,
    TGT_IND,
    TGT_RET
  } tgt_sel_e;

  typedef enum logic [2:0] {
    CND_NEVER,
    CND_ALWAYS,
    CND_FLAG,
    CND_NONZERO,
    CND_DIFFER
  } cnd_kind_e;

  typedef struct packed {
    tgt_sel_e  tgt;
    cnd_kind_e cnd;
  } br_dec_t;

  function automatic br_dec_t decode_branch(input logic [7:0] op);
    br_dec_t d;
    d.tgt = TGT_SEQ;
    d.cnd = CND_NEVER;
    if (op inside {[8'hC0:8'hCF]}) begin
      d.tgt = TGT_PAGE;   d.cnd = CND_ALWAYS;
    end else if (op inside {[8'hD0:8'hD3]}) begin
      d.tgt = TGT_REL_B1; d.cnd = CND_NONZERO;
    end else if (op inside {[8'hD4:8'hD7], 8'hDF}) begin
      d.tgt = TGT_REL_B2; d.cnd = CND_DIFFER;
    end else if (op inside {8'hD8, 8'hD9}) begin
      d.tgt = TGT_LONG;   d.cnd = CND_ALWAYS;
    end else if (op inside {8'hDA, 8'hDB}) begin
      d.tgt = TGT_RET;    d.cnd = CND_ALWAYS;
    end else if (op == 8'hDC) begin
      d.tgt = TGT_REL_B1; d.cnd = CND_ALWAYS;
    end else if (op == 8'hDD) begin
      d.tgt = TGT_IDX;    d.cnd = CND_ALWAYS;
    end else if (op == 8'hDE) begin
      d.tgt = TGT_IND;    d.cnd = CND_ALWAYS;
    end else if (op inside {[8'hE0:8'hE7]}) begin
      d.tgt = TGT_REL_B1; d.cnd = CND_FLAG;
    end
    return d;
  endfunction

endpackage

// File: rtl/npc_len_dec.sv
module npc_len_dec #(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [1:0]       len
);

  always_comb begin
    if (opcode inside {8'h16, 8'h17, 8'h18, 8'h19, 8'h1C, 8'h1D,
                       [8'hD4:8'hD9], 8'hDF})
      len = 2'd3;
    else if (opcode inside {8'h15, [8'h28:8'h2F], 8'h86, 8'h8E, 8'h96,
                            8'hA6, 8'hAE, 8'hB6, 8'hBE, [8'hC0:8'hD3],
                            8'hDC, [8'hE0:8'hE7], [8'hFC:8'hFE]})
      len = 2'd2;
    else
      len = 2'd1;
  end

  always_comb begin
    // R1
    len_range_chk: assert (len != 2'd0)
      else $error("opcode length decoded as zero");
  end

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int D_W     = 8,
  parameter int N_FLAGS = 4
) (
  input  cnd_kind_e      cnd,
  input  logic [2:0]     sel,
  input  logic [N_FLAGS-1:0] flags,
  input  logic [D_W-1:0] loop_val,
  input  logic [D_W-1:0] imm,
  output logic           taken
);

  localparam int SEL_W = $clog2(N_FLAGS);

  logic [N_FLAGS-1:0] flag_hit;
  logic               flag_ok;

  // each flag pair: even code tests the flag set, odd code tests it clear
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    assign flag_hit[g] = flags[g] ^ sel[0];
  end

  assign flag_ok = flag_hit[sel[SEL_W:1]];

  always_comb begin
    unique case (cnd)
      CND_ALWAYS:  taken = 1'b1;
      CND_FLAG:    taken = flag_ok;
      CND_NONZERO: taken = (loop_val != '0);
      CND_DIFFER:  taken = (loop_val != imm);
      default:     taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int D_W     = 8,
  parameter int PG_BITS = 3
) (
  input  tgt_sel_e          tgt,
  input  logic [PC_W-D_W-PG_BITS-1:0] pc_hi,
  input  logic [PG_BITS-1:0] page,
  input  logic [PC_W-1:0]   seq_pc,
  input  logic [D_W-1:0]    b1,
  input  logic [D_W-1:0]    b2,
  input  logic [D_W-1:0]    acc,
  input  logic [PC_W-1:0]   dptr,
  input  logic [PC_W-1:0]   ret_addr,
  output logic [PC_W-1:0]   target
);

  localparam int EXT_W = PC_W - D_W;

  logic [D_W-1:0]  rel_byte;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] idx_pc;

  assign rel_byte = (tgt == TGT_REL_B2) ? b2 : b1;
  assign rel_pc   = seq_pc + {{EXT_W{rel_byte[D_W-1]}}, rel_byte};
  assign idx_pc   = dptr + {{EXT_W{1'b0}}, acc};

  always_comb begin
    unique case (tgt)
      TGT_PAGE:   target = {pc_hi, page, b1};
      TGT_LONG:   target = {b1, b2};
      TGT_REL_B1,
      TGT_REL_B2: target = rel_pc;
      TGT_IDX:    target = idx_pc;
      TGT_IND:    target = dptr;
      TGT_RET:    target = ret_addr;
      default:    target = seq_pc;
    endcase
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int D_W  = 8
) (
  input  logic [15:0] pc,
  input  logic [7:0]  opcode,
  input  logic [7:0]  opnd1,
  input  logic [7:0]  opnd2,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        flag_zero,
  input  logic        flag_carry,
  input  logic        flag_par_odd,
  input  logic        flag_sign,
  input  logic [7:0]  loop_val,
  input  logic [15:0] ret_addr,
  output logic [15:0] next_pc,
  output logic        taken,
  output logic [15:0] push_addr
);

  localparam int PG_BITS = 3;
  localparam int N_FLAGS = 4;
  localparam int HI_LSB  = D_W + PG_BITS;

  br_dec_t         dec;
  logic [1:0]      len;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] target;
  logic [N_FLAGS-1:0] flags;

  assign dec   = decode_branch(opcode);
  assign flags = {flag_sign, flag_par_odd, flag_carry, flag_zero};

  npc_len_dec #(.OPC_W(D_W)) u_len (
    .opcode (opcode),
    .len    (len)
  );

  assign seq_pc = pc + {{(PC_W-2){1'b0}}, len};

  npc_cond_eval #(.D_W(D_W), .N_FLAGS(N_FLAGS)) u_cond (
    .cnd      (dec.cnd),
    .sel      (opcode[2:0]),
    .flags    (flags),
    .loop_val (loop_val),
    .imm      (opnd1),
    .taken    (taken)
  );

  npc_target #(.PC_W(PC_W), .D_W(D_W), .PG_BITS(PG_BITS)) u_tgt (
    .tgt      (dec.tgt),
    .pc_hi    (pc[PC_W-1:HI_LSB]),
    .page     (opcode[PG_BITS-1:0]),
    .seq_pc   (seq_pc),
    .b1       (opnd1),
    .b2       (opnd2),
    .acc      (acc),
    .dptr     (dptr),
    .ret_addr (ret_addr),
    .target   (target)
  );

  assign next_pc   = taken ? target : seq_pc;
  assign push_addr = seq_pc;

  always_comb begin
    // R1
    seq_path_chk: assert (taken || next_pc == push_addr)
      else $error("untaken path left the sequential address");
    // R2
    nonbranch_chk: assert (opcode inside {[8'hC0:8'hE7]} || !taken)
      else $error("non-branch opcode reported taken");
    // R3
    page_bits_chk: assert (opcode[7:4] != 4'hC ||
                           (taken && next_pc[10:8] == opcode[2:0] &&
                            next_pc[15:11] == pc[15:11]))
      else $error("page target bits wrong");
    // R10
    return_chk: assert (!(opcode inside {8'hDA, 8'hDB}) ||
                        (taken && next_pc == ret_addr))
      else $error("return did not load popped address");
  end

endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

  logic        clk;
  logic [15:0] pc, dptr, ret_addr;
  logic [7:0]  opcode, opnd1, opnd2, acc, loop_val;
  logic        flag_zero, flag_carry, flag_par_odd, flag_sign;
  logic [15:0] next_pc, push_addr;
  logic        taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  npc_unit dut (
    .pc(pc), .opcode(opcode), .opnd1(opnd1), .opnd2(opnd2), .acc(acc),
    .dptr(dptr), .flag_zero(flag_zero), .flag_carry(flag_carry),
    .flag_par_odd(flag_par_odd), .flag_sign(flag_sign),
    .loop_val(loop_val), .ret_addr(ret_addr),
    .next_pc(next_pc), .taken(taken), .push_addr(push_addr)
  );

  function automatic int op_len(input logic [7:0] op);
    if (op == 8'h16 || op == 8'h17 || op == 8'h18 || op == 8'h19 ||
        op == 8'h1C || op == 8'h1D || (op >= 8'hD4 && op <= 8'hD9) ||
        op == 8'hDF) return 3;
    if (op == 8'h15 || (op >= 8'h28 && op <= 8'h2F) || op == 8'h86 ||
        op == 8'h8E || op == 8'h96 || op == 8'hA6 || op == 8'hAE ||
        op == 8'hB6 || op == 8'hBE || (op >= 8'hC0 && op <= 8'hD3) ||
        op == 8'hDC || (op >= 8'hE0 && op <= 8'hE7) ||
        (op >= 8'hFC && op <= 8'hFE)) return 2;
    return 1;
  endfunction

  function automatic logic [15:0] sx(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%02h pc=%04h actual=%04h expected=%04h",
               req, what, opcode, pc, act, exp);
    end
  endtask

  task automatic apply_and_check();
    logic [15:0] seq, exp_pc;
    logic        exp_tk;
    string       tag;
    logic [3:0]  fv;
    seq    = pc + 16'(op_len(opcode));
    exp_pc = seq;
    exp_tk = 1'b0;
    tag    = (opcode <= 8'h07 || opcode == 8'hFB) ? "R2" : "R1";
    fv     = {flag_sign, flag_par_odd, flag_carry, flag_zero};
    if (opcode >= 8'hC0 && opcode <= 8'hCF) begin
      tag = "R3"; exp_tk = 1'b1; exp_pc = {pc[15:11], opcode[2:0], opnd1};
    end else if (opcode == 8'hD8 || opcode == 8'hD9) begin
      tag = "R4"; exp_tk = 1'b1; exp_pc = {opnd1, opnd2};
    end else if (opcode == 8'hDC) begin
      tag = "R5"; exp_tk = 1'b1; exp_pc = seq + sx(opnd1);
    end else if (opcode == 8'hDD) begin
      tag = "R6"; exp_tk = 1'b1; exp_pc = dptr + {8'h00, acc};
    end else if (opcode == 8'hDE) begin
      tag = "R6"; exp_tk = 1'b1; exp_pc = dptr;
    end else if (opcode >= 8'hE0 && opcode <= 8'hE7) begin
      tag = "R7";
      exp_tk = fv[opcode[2:1]] ? !opcode[0] : opcode[0];
      if (exp_tk) exp_pc = seq + sx(opnd1);
    end else if (opcode >= 8'hD0 && opcode <= 8'hD3) begin
      tag = "R8"; exp_tk = (loop_val != 8'h00);
      if (exp_tk) exp_pc = seq + sx(opnd1);
    end else if ((opcode >= 8'hD4 && opcode <= 8'hD7) || opcode == 8'hDF) begin
      tag = "R9"; exp_tk = (loop_val != opnd1);
      if (exp_tk) exp_pc = seq + sx(opnd2);
    end else if (opcode == 8'hDA || opcode == 8'hDB) begin
      tag = "R10"; exp_tk = 1'b1; exp_pc = ret_addr;
    end
    if (pc >= 16'hFFFD) tag = {tag, "/R12"};
    @(negedge clk);
    check(tag, next_pc, exp_pc, "next_pc");
    check(tag, {15'd0, taken}, {15'd0, exp_tk}, "taken");
    check("R11", push_addr, seq, "push_addr");
  endtask

  initial begin
    pc = 16'h0000; opcode = 8'h00; opnd1 = 8'h00; opnd2 = 8'h00;
    acc = 8'h00; dptr = 16'h0000; ret_addr = 16'h0000; loop_val = 8'h00;
    {flag_sign, flag_par_odd, flag_carry, flag_zero} = 4'h0;
    @(negedge clk);
    // R1: opcode 0x00 at address 0 advances by one
    check("R1", next_pc, 16'h0001, "idle next_pc");
    for (int pi = 0; pi < 4; pi++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int op = 0; op < 256; op++) begin
          @(posedge clk);
          case (pi)
            0: pc = 16'h1234;
            1: pc = 16'hFFFF;
            2: pc = 16'h07FE;
            default: pc = 16'h0001;
          endcase
          opcode   = 8'(op);
          {flag_sign, flag_par_odd, flag_carry, flag_zero} = 4'(fl);
          opnd1    = fl[0] ? 8'h85 : 8'h35;
          opnd2    = fl[3] ? 8'hC3 : 8'h41;
          acc      = 8'hF0 + 8'(fl);
          dptr     = 16'hFFF8 + 16'(pi);
          ret_addr = 16'hA5A0 + 16'(fl);
          loop_val = fl[1] ? opnd1 : (fl[2] ? 8'h00 : 8'h5A);
          apply_and_check();
        end
      end
    end
    // R12: 3-byte opcode at 0xFFFE wraps to 0x0001
    @(posedge clk);
    pc = 16'hFFFE; opcode = 8'h17;
    @(negedge clk);
    check("R12", next_pc, 16'h0001, "wrap next_pc");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule